// File: doc/BRIEF.md
# Real-Time Clock Register Sync Master

This block is a bit-level I2C bus master that keeps a seven-register real-time clock device in step with the host logic. It drives the clock and data wires as open-drain outputs: a pin's output enable high pulls the wire low, and low releases it to its pull-up. The data wire is read back through an input sample. After reset it performs one write transaction. That transaction loads seven BCD bytes taken from `init_time` into the device, starting at register offset 0. After the write it runs read passes for ever. Each read pass fetches all seven registers and presents them as one word on a valid/ready output.

The result interface follows valid/ready rules. `rd_valid` rises when a pass has ended and the bus has been released. `rd_valid` and `rd_data` then hold without change until a cycle in which `rd_ready` is high. The next read pass does not begin until the word has been taken, so a slow consumer slows the bus instead of losing data. A NACK from the device during any byte the master writes is handled the same way in every phase. The master sends a Stop, pulses `err_pulse` for one cycle and runs the current phase again from its first Start.

Top module: `rtc_sync_master`

## Requirements
- R1: While reset is asserted, `scl_oe` and `sda_oe` are both 0, so both wires are released, and `rd_valid` and `err_pulse` are 0.
- R2: The data wire changes level only while the clock wire is steady. A Start is the data wire falling while the clock wire is high. A Stop is the data wire rising while the clock wire is high. Data bits change only while the clock wire is low.
- R3: After reset the first completed transaction is a write, sent exactly once: Start, address byte `{DEV_ADDR,0}` (0xD0 by default), pointer byte 0x00, then the seven bytes `init_time[8k+7:8k]` for k = 0 to 6, then Stop. Every byte is sent MSB first and the device ACKs each one.
- R4: Each read pass is: Start, `{DEV_ADDR,0}`, 0x00, repeated Start, `{DEV_ADDR,1}` (0xD1), then seven bytes read from the device. The master drives ACK (low) after the first six bytes and leaves NACK (high) after the seventh. The pass ends with Stop.
- R5: At the end of a pass, `rd_data[8k+7:8k]` holds the k-th byte read in that pass. `rd_valid` rises only when both wires are released.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` stay constant and both wires stay released. No new pass starts until the word has been accepted.
- R7: If the device NACKs an address, pointer or data byte that the master writes, the master sends Stop and pulses `err_pulse` high for exactly one cycle. It then repeats the current phase (the write phase, or the current read pass) from its Start.
- R8: Within a byte, consecutive rising edges of the clock wire are exactly 4×`QTR_DIV` system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_time | input | 8*NUM_REGS | BCD bytes written once after reset; byte k goes to register k |
| scl_oe | output | 1 | 1 pulls the clock wire low |
| sda_oe | output | 1 | 1 pulls the data wire low |
| sda_in | input | 1 | Sampled level of the data wire |
| rd_data | output | 8*NUM_REGS | Registers from the last read pass, register k in byte k |
| rd_valid | output | 1 | `rd_data` holds a complete pass |
| rd_ready | input | 1 | Consumer accepts `rd_data` in this cycle |
| err_pulse | output | 1 | One-cycle pulse on a NACK to a written byte |

## Verification
Each bit takes four quarter periods of `QTR_DIV` cycles. The clock wire rises in the second quarter and the data wire is sampled in the third, so a level the device puts out when the clock falls is read three quarters later. That leaves room for the two-stage input synchronizer. `err_pulse` appears in the cycle after the ninth bit's last quarter. `rd_valid` rises in the cycle after the Stop's last quarter, and it drops in the cycle after a handshake edge. The bench samples the wires on the falling system clock edge and decodes Start, Stop, bytes and ACK levels as they happen, comparing each against a queue of expected events. Results are checked when a handshake occurs. The checks compare the rise-to-rise interval against 4×`QTR_DIV` exactly, so any extra register on the clock path would show up.

// File: rtl/rtc_sync_pkg.sv
package rtc_sync_pkg;

  // Commands passed from the transaction sequencer to the bit engine.
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  // Quarter periods per bit slot.
  localparam int unsigned QUARTERS = 4;

endpackage

// File: rtl/rtc_sync_tick.sv
module rtc_sync_tick #(
  parameter int unsigned DIV = 313
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sync_phy.sv
module rtc_sync_phy
  import rtc_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       op_valid,
  input  bus_op_e    op,
  input  logic [7:0] op_byte,
  input  logic       op_nack,
  output logic       op_ready,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_seen,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic       busy;
  bus_op_e    cur;
  logic [7:0] sh;
  logic [3:0] bitn;
  logic [1:0] q;
  logic       last;
  logic       sda_s1, sda_s2;
  logic       is_wr;

  assign op_ready = !busy;
  assign is_wr    = (cur == OP_WRITE);

  // Two-stage synchronizer for the wire sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur      <= OP_STOP;
      sh       <= '0;
      bitn     <= '0;
      q        <= '0;
      last     <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
      ack_seen <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (op_valid) begin
          busy <= 1'b1;
          cur  <= op;
          sh   <= op_byte;
          last <= op_nack;
          bitn <= '0;
          q    <= '0;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        case (cur)
          OP_START: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1;
                busy   <= 1'b0;
                done   <= 1'b1;
              end
            endcase
          end
          OP_STOP: begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            endcase
          end
          default: begin
            case (q)
              2'd0: begin
                if (bitn[3]) sda_oe <= is_wr ? 1'b0 : !last;
                else         sda_oe <= is_wr ? !sh[7] : 1'b0;
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn[3]) begin
                  ack_seen <= !sda_s2;
                end else begin
                  rx_byte <= {rx_byte[6:0], sda_s2};
                  sh      <= {sh[6:0], 1'b0};
                end
              end
              default: begin
                scl_oe <= 1'b1;
                if (bitn[3]) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_sync_seq.sv
module rtc_sync_seq
  import rtc_sync_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8*NUM_REGS-1:0]   init_time,
  output logic                    op_valid,
  output bus_op_e                 op,
  output logic [7:0]              op_byte,
  output logic                    op_nack,
  input  logic                    op_ready,
  input  logic                    done,
  input  logic [7:0]              rx_byte,
  input  logic                    ack_seen,
  output logic [8*NUM_REGS-1:0]   out_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    err
);
  localparam int unsigned WR_DATA = 3;
  localparam int unsigned WR_STOP = WR_DATA + NUM_REGS;
  localparam int unsigned RD_DATA = 5;
  localparam int unsigned RD_STOP = RD_DATA + NUM_REGS;
  localparam int unsigned SW      = $clog2(RD_STOP + 1);

  logic          reading;
  logic          waiting;
  logic          retry;
  logic [SW-1:0] step;
  int            s;

  assign s = int'(step);
  assign op_valid = !waiting && !(reading && !retry && (step == '0) && out_valid);

  // Script decode: the command for the current phase and step.
  always_comb begin
    op      = OP_STOP;
    op_byte = '0;
    op_nack = 1'b0;
    if (retry) begin
      op = OP_STOP;
    end else if (!reading) begin
      if (s == 0) begin
        op = OP_START;
      end else if (s == 1) begin
        op      = OP_WRITE;
        op_byte = {DEV_ADDR, 1'b0};
      end else if (s == 2) begin
        op      = OP_WRITE;
        op_byte = 8'h00;
      end else if (s < WR_STOP) begin
        op = OP_WRITE;
        for (int k = 0; k < NUM_REGS; k++)
          if (s == WR_DATA + k) op_byte = init_time[8*k +: 8];
      end
    end else begin
      if (s == 0 || s == 3) begin
        op = OP_START;
      end else if (s == 1) begin
        op      = OP_WRITE;
        op_byte = {DEV_ADDR, 1'b0};
      end else if (s == 2) begin
        op      = OP_WRITE;
        op_byte = 8'h00;
      end else if (s == 4) begin
        op      = OP_WRITE;
        op_byte = {DEV_ADDR, 1'b1};
      end else if (s < RD_STOP) begin
        op      = OP_READ;
        op_nack = (s == RD_STOP - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading   <= 1'b0;
      waiting   <= 1'b0;
      retry     <= 1'b0;
      step      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!waiting) begin
        if (op_valid && op_ready) waiting <= 1'b1;
      end else if (done) begin
        waiting <= 1'b0;
        if (op == OP_WRITE && !ack_seen) begin
          retry <= 1'b1;
          err   <= 1'b1;
          step  <= reading ? SW'(RD_STOP) : SW'(WR_STOP);
        end else if (op == OP_STOP) begin
          step  <= '0;
          retry <= 1'b0;
          if (!retry) begin
            if (!reading) reading   <= 1'b1;
            else          out_valid <= 1'b1;
          end
        end else begin
          if (op == OP_READ) begin
            for (int k = 0; k < NUM_REGS; k++)
              if (s == RD_DATA + k) out_data[8*k +: 8] <= rx_byte;
          end
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_sync_master.sv
module rtc_sync_master
  import rtc_sync_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned QTR_DIV  = 313
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*NUM_REGS-1:0] init_time,
  output logic                  scl_oe,
  output logic                  sda_oe,
  input  logic                  sda_in,
  output logic [8*NUM_REGS-1:0] rd_data,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic                  err_pulse
);
  logic       tick;
  logic       op_valid, op_ready, op_nack, done, ack_seen;
  bus_op_e    op;
  logic [7:0] op_byte, rx_byte;

  rtc_sync_tick #(.DIV(QTR_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rtc_sync_seq #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_time(init_time),
    .op_valid (op_valid),
    .op       (op),
    .op_byte  (op_byte),
    .op_nack  (op_nack),
    .op_ready (op_ready),
    .done     (done),
    .rx_byte  (rx_byte),
    .ack_seen (ack_seen),
    .out_data (rd_data),
    .out_valid(rd_valid),
    .out_ready(rd_ready),
    .err      (err_pulse)
  );

  rtc_sync_phy u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .op_valid(op_valid),
    .op      (op),
    .op_byte (op_byte),
    .op_nack (op_nack),
    .op_ready(op_ready),
    .done    (done),
    .rx_byte (rx_byte),
    .ack_seen(ack_seen),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .sda_in  (sda_in)
  );
endmodule

// File: rtl/rtc_sync_chk.sv
module rtc_sync_chk #(
  parameter int unsigned DW = 56
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          err_pulse
);
  AST_RELEASED_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (!scl_oe && !sda_oe && !rd_valid && !err_pulse)); // R1

  AST_SDA_MOVES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $stable(scl_oe)); // R2

  AST_PUBLISH_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (!scl_oe && !sda_oe)); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6

  AST_HOLD_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (!scl_oe && !sda_oe)); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R7
endmodule

bind rtc_sync_master rtc_sync_chk #(.DW(8*NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .err_pulse(err_pulse)
);

// File: tb/test_rtc_sync_master.sv
module test_rtc_sync_master;
  localparam int unsigned QD   = 4;
  localparam int unsigned NR   = 7;
  localparam logic [6:0]  ADDR = 7'h68;
  localparam logic [55:0] INIT = 56'h24_02_28_03_11_59_45;
  localparam logic [55:0] PAT2 = 56'h99_12_31_07_23_59_59;
  localparam logic [55:0] PAT3 = 56'h00_01_01_01_00_00_00;
  localparam int EV_START = 0, EV_STOP = 1, EV_BYTE = 2;

  typedef struct {
    int         kind;
    logic [7:0] b;
    logic       ack;
    string      tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [55:0] init_time = INIT;
  logic        scl_oe, sda_oe, rd_valid, err_pulse;
  logic        rd_ready = 1'b0;
  logic [55:0] rd_data;
  logic        s_pull = 1'b0;
  wire         sda_line = !(sda_oe || s_pull);

  int checks = 0, failures = 0;
  int unsigned cyc = 0;
  bit finished = 0;

  ev_t         exp_q[$];
  logic [55:0] out_q[$];

  // slave model and monitor state
  logic [7:0] regs [0:7];
  logic [7:0] sh, txb;
  int  bcnt = 0, byte_idx = 0, nack_at = -1, ptr = 0, err_cnt = 0;
  int  per_n = 0, per_bad = 0;
  int unsigned last_rise = 0;
  bit  pscl = 1, psda = 1, addr_ph = 0, rd_mode = 0, expect_ptr = 0, tx_on = 0, mack = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_sync_master #(.DEV_ADDR(ADDR), .NUM_REGS(NR), .QTR_DIV(QD)) i_rtc_sync_master (
    .clk(clk), .rst_n(rst_n), .init_time(init_time),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .err_pulse(err_pulse)
  );

  task automatic push_ev(input int kind, input logic [7:0] b, input logic a, input string tag);
    ev_t e;
    e.kind = kind; e.b = b; e.ack = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_nack_txn(input int idx);
    push_ev(EV_START, 8'h00, 1'b0, "R7");
    push_ev(EV_BYTE, {ADDR, 1'b0}, idx == 0, "R7");
    if (idx == 1) push_ev(EV_BYTE, 8'h00, 1'b1, "R7");
    push_ev(EV_STOP, 8'h00, 1'b0, "R7");
  endtask

  task automatic exp_write_phase(input logic [55:0] d);
    push_ev(EV_START, 8'h00, 1'b0, "R2");
    push_ev(EV_BYTE, {ADDR, 1'b0}, 1'b0, "R3");
    push_ev(EV_BYTE, 8'h00, 1'b0, "R3");
    for (int k = 0; k < NR; k++) push_ev(EV_BYTE, d[8*k +: 8], 1'b0, "R3");
    push_ev(EV_STOP, 8'h00, 1'b0, "R2");
  endtask

  task automatic exp_read_pass(input logic [55:0] d);
    push_ev(EV_START, 8'h00, 1'b0, "R2");
    push_ev(EV_BYTE, {ADDR, 1'b0}, 1'b0, "R4");
    push_ev(EV_BYTE, 8'h00, 1'b0, "R4");
    push_ev(EV_START, 8'h00, 1'b0, "R4");
    push_ev(EV_BYTE, {ADDR, 1'b1}, 1'b0, "R4");
    for (int k = 0; k < NR; k++) push_ev(EV_BYTE, d[8*k +: 8], k == NR - 1, "R4");
    push_ev(EV_STOP, 8'h00, 1'b0, "R2");
    out_q.push_back(d);
  endtask

  task automatic got_ev(input int kind, input logic [7:0] b, input logic a);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R6 unexpected bus event kind=%0d byte=%h ack=%b, expected none", kind, b, a);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || (kind == EV_BYTE && (e.b != b || e.ack != a))) begin
        failures++;
        $display("FAIL %s bus event kind=%0d byte=%h ack=%b, expected kind=%0d byte=%h ack=%b",
                 e.tag, kind, b, a, e.kind, e.b, e.ack);
      end
    end
  endtask

  task automatic set_regs(input logic [55:0] d);
    for (int k = 0; k < NR; k++) regs[k] = d[8*k +: 8];
  endtask

  // Monitor, slave model and result scoreboard, sampled away from the active edge.
  always @(negedge clk) begin
    bit scl_now, sda_now, nak;
    logic [55:0] e;
    if (!rst_n) begin
      pscl = 1; psda = 1; bcnt = 0; s_pull = 0;
    end else begin
      scl_now = !scl_oe;
      sda_now = sda_line;
      if (err_pulse) err_cnt++;
      if (rd_valid && rd_ready) begin
        checks++;
        if (out_q.size() == 0) begin
          failures++;
          $display("FAIL R5 result %h accepted, expected none", rd_data);
        end else begin
          e = out_q.pop_front();
          if (rd_data !== e) begin
            failures++;
            $display("FAIL R5 rd_data=%h expected %h", rd_data, e);
          end
        end
      end
      if (pscl && scl_now && psda && !sda_now) begin
        got_ev(EV_START, 8'h00, 1'b0);
        bcnt = 0; byte_idx = 0; addr_ph = 1; tx_on = 0; rd_mode = 0; s_pull = 0;
      end else if (pscl && scl_now && !psda && sda_now) begin
        got_ev(EV_STOP, 8'h00, 1'b0);
        bcnt = 0; addr_ph = 0; tx_on = 0; rd_mode = 0; s_pull = 0;
      end else if (!pscl && scl_now) begin
        if (bcnt >= 1 && bcnt <= 8) begin
          per_n++;
          if (cyc - last_rise != 4 * QD) per_bad++;
        end
        last_rise = cyc;
        if (bcnt < 8) begin
          sh = {sh[6:0], sda_now};
          bcnt++;
        end else if (bcnt == 8) begin
          if (tx_on) begin
            got_ev(EV_BYTE, txb, sda_now);
            mack = sda_now;
          end else begin
            got_ev(EV_BYTE, sh, sda_now);
          end
          bcnt = 9;
        end
      end else if (pscl && !scl_now) begin
        if (bcnt == 8) begin
          if (tx_on) begin
            s_pull = 0;
          end else begin
            nak = (byte_idx == nack_at) || (addr_ph && sh[7:1] != ADDR);
            if (byte_idx == nack_at) nack_at = -1;
            s_pull = !nak;
            if (!nak) begin
              if (addr_ph) begin
                rd_mode = sh[0];
                expect_ptr = !sh[0];
              end else if (expect_ptr) begin
                ptr = int'(sh);
                expect_ptr = 0;
              end else begin
                regs[ptr % 8] = sh;
                ptr++;
              end
            end
            addr_ph = 0;
            byte_idx++;
          end
        end else if (bcnt == 9) begin
          bcnt = 0;
          s_pull = 0;
          if (rd_mode && (!tx_on || !mack)) begin
            tx_on = 1;
            txb = regs[ptr % 8];
            ptr++;
            s_pull = !txb[7];
          end else if (tx_on) begin
            tx_on = 0;
            rd_mode = 0;
          end
        end else if (tx_on && bcnt >= 1 && bcnt <= 7) begin
          s_pull = !txb[7 - bcnt];
        end
      end
      pscl = scl_now;
      psda = sda_now;
    end
  end

  task automatic accept();
    @(posedge clk); #1 rd_ready = 1'b1;
    @(posedge clk); #1 rd_ready = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!rd_valid);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired, expected run to complete");
    finish_run();
  end

  initial begin
    logic [55:0] held;
    bit bad;
    for (int k = 0; k < 8; k++) regs[k] = 8'h00;
    nack_at = 1;
    repeat (5) @(negedge clk);
    checks++;
    if (scl_oe !== 1'b0 || sda_oe !== 1'b0 || rd_valid !== 1'b0 || err_pulse !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs scl_oe=%b sda_oe=%b valid=%b err=%b, expected 0 0 0 0",
               scl_oe, sda_oe, rd_valid, err_pulse);
    end
    exp_nack_txn(1);       // R7 pointer byte refused in the write phase
    exp_write_phase(INIT); // R3
    exp_read_pass(INIT);   // R4
    @(posedge clk); #1 rst_n = 1'b1;

    wait_valid();
    held = rd_data;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (!rd_valid || rd_data !== held || scl_oe || sda_oe) bad = 1;
    end
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL R6 hold broken valid=%b data=%h bus=%b%b, expected 1 %h 00",
               rd_valid, rd_data, scl_oe, sda_oe, held);
    end

    set_regs(PAT2);
    nack_at = 0;
    exp_nack_txn(0);       // R7 address refused in a read pass
    exp_read_pass(PAT2);
    accept();
    wait_valid();

    set_regs(PAT3);
    exp_read_pass(PAT3);
    accept();
    wait_valid();
    accept();
    repeat (2) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R4 pending bus events=%0d, expected 0", exp_q.size());
    end
    checks++;
    if (out_q.size() != 0) begin
      failures++;
      $display("FAIL R5 pending results=%0d, expected 0", out_q.size());
    end
    checks++;
    if (err_cnt != 2) begin
      failures++;
      $display("FAIL R7 err pulses=%0d, expected 2", err_cnt);
    end
    checks++;
    if (per_bad != 0 || per_n == 0) begin
      failures++;
      $display("FAIL R8 bad clock intervals=%0d of %0d, expected 0 (period %0d)",
               per_bad, per_n, 4 * QD);
    end
    finish_run();
  end
endmodule